// File: doc/BRIEF.md
# Complementary PWM Timer with Dead-Time Insertion

This block is a free-running up-counter behind a power-of-two clock divider. It drives a pair of complementary PWM outputs. The counter steps from 1 to a reload limit. A compare value splits each period into a primary-on phase and a complement-on phase. Whenever a phase begins, the output that is about to turn on stays at its inactive level for a programmable number of system clock cycles. This dead time keeps the two outputs from ever being active together, which matters when they drive the two switches of a half bridge.

A single polarity bit selects the levels of both outputs. A change to that bit while the timer runs is held back until the next phase boundary, so no glitch appears in the middle of a phase. A second mode turns the block into an edge timestamp unit. An external input is synchronised, the selected edge is detected, and the running count is stored and flagged. All settings arrive as plain register-style inputs from the surrounding logic.

Top module: `pwm_deadband_timer`

## Requirements
- R1: A prescaled tick occurs once every 2^prescale system clock cycles, so with reload value N (N ≥ 2) successive reload pulses are N·2^prescale cycles apart.
- R2: While enable is low, the divider and the counter are cleared. The first reload pulse after enable rises appears in the cycle whose index is N·2^prescale, counting the first enabled cycle as index 0.
- R3: The counter runs from 1 to N. On the tick taken at N it returns to 1, and reloadPulse is high for exactly one cycle, in the cycle after that tick.
- R4: While disabled, outPri equals the live polarity bit and outComp is its inverse. With polarity 1 this gives primary high and complement low.
- R5: In PWM mode, the active level of each output equals the latched polarity. The primary is active from a reload until the tick taken at count == compare value. The complement is active from there until the next reload. Per period, the primary is active for C·2^prescale − D cycles and the complement for (N−C)·2^prescale − D cycles, where 1 ≤ C < N.
- R6: After each reload or compare event, both outputs sit at their inactive level for D system clock cycles, where D is the 3-bit dead-time input. Each period therefore has exactly 2·D cycles with both outputs inactive.
- R7: Both outputs are never at their active level in the same cycle.
- R8: A polarity change while PWM runs leaves the outputs unchanged until the next reload or compare event, where the new polarity takes effect.
- R9: In capture mode, polarity 0 selects a rising edge of timerIn and polarity 1 a falling edge. The other edge, or any edge while disabled or in PWM mode, produces no capture.
- R10: A selected edge stores the current count in captureVal and raises captureFlag for one cycle. The flag appears in the third cycle after timerIn changes, because of the two-stage synchroniser and the edge register.
- R11: In capture mode the PWM outputs hold the disabled levels of the live polarity, and the counter still wraps at N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the timer; low clears divider and counter |
| capMode | input | 1 | 1 = edge capture mode, 0 = complementary PWM mode |
| polarity | input | 1 | Output level select (PWM) or capture edge select |
| prescale | input | PRE_W | Divider exponent, divide by 2^prescale |
| reloadVal | input | CNT_W | Final count of a period |
| pwmVal | input | CNT_W | Compare value ending the primary phase |
| deadband | input | DB_W | Dead time in system clock cycles |
| timerIn | input | 1 | Asynchronous capture input |
| outPri | output | 1 | Primary PWM output |
| outComp | output | 1 | Complementary PWM output |
| reloadPulse | output | 1 | One-cycle pulse after each wrap |
| captureVal | output | CNT_W | Count stored at the last capture |
| captureFlag | output | 1 | One-cycle pulse on each capture |

## Verification
The bench builds the timer with its default parameters: a 16-bit counter, a 3-bit divider exponent and a 3-bit dead time. With these values the full divide-by-128 range is reachable, so the capture test can hold the count steady across a slow tick and compare stored counts exactly. The maximum dead time of 7 cycles can be set larger than a whole phase at small dividers, which is the case where the off-time accounting is easiest to get wrong. Vectors mix divider settings 1, 2 and 4 with both polarities, so phase lengths, dead cycles and output levels are all checked against closed-form counts.

// File: rtl/pwmdb_pkg.sv
package pwmdb_pkg;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic tick;     // prescaled count enable
    logic capEdge;  // qualified capture edge
  } ctrlStrobe_t;

  typedef enum logic {
    PH_PRI  = 1'b0,
    PH_COMP = 1'b1
  } phase_t;

endpackage

// File: rtl/pwmdb_ctrl.sv
module pwmdb_ctrl
  import pwmdb_pkg::*;
#(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             capMode,
  input  logic             polarity,
  input  logic [PRE_W-1:0] prescale,
  input  logic             timerIn,
  output ctrlStrobe_t      strobe
);

  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] preCnt;
  logic [DIV_W-1:0] preMask;
  logic [2:0]       syncQ;
  logic             riseSeen;
  logic             fallSeen;

  assign preMask = DIV_W'((32'd1 << prescale) - 32'd1);

  always_comb begin
    strobe.tick    = enable && (preCnt == preMask);
    riseSeen       = syncQ[1] && !syncQ[2];
    fallSeen       = !syncQ[1] && syncQ[2];
    strobe.capEdge = enable && capMode && (polarity ? fallSeen : riseSeen);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt <= '0;
    end else if (!enable || strobe.tick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ <= '0;
    end else begin
      syncQ <= {syncQ[1:0], timerIn};
    end
  end

  AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> preCnt == '0);  // R2

  AST_TICK_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.tick && prescale != '0) |=> (!strobe.tick || prescale != $past(prescale)));  // R1

endmodule

// File: rtl/pwmdb_datapath.sv
module pwmdb_datapath
  import pwmdb_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DB_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             capMode,
  input  logic             polarity,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic [CNT_W-1:0] pwmVal,
  input  logic [DB_W-1:0]  deadband,
  input  ctrlStrobe_t      strobe,
  output logic             outPri,
  output logic             outComp,
  output logic             reloadPulse,
  output logic [CNT_W-1:0] captureVal,
  output logic             captureFlag
);

  logic [CNT_W-1:0] count;
  logic [DB_W-1:0]  deadCnt;
  phase_t           phase;
  logic             latPol;
  logic             wrapEv;
  logic             matchEv;
  logic             idleOut;
  logic             rawPri;
  logic             rawComp;

  always_comb begin
    wrapEv  = strobe.tick && (count >= reloadVal);
    matchEv = strobe.tick && !wrapEv && !capMode && (count == pwmVal);
    idleOut = !enable || capMode;
    rawPri  = (phase == PH_PRI) && (deadCnt == '0);
    rawComp = (phase == PH_COMP) && (deadCnt == '0);
    outPri  = idleOut ? polarity  : (latPol ? rawPri : !rawPri);
    outComp = idleOut ? !polarity : (latPol ? rawComp : !rawComp);
  end

  // Counter and reload pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count       <= CNT_W'(1);
      reloadPulse <= 1'b0;
    end else begin
      reloadPulse <= wrapEv;
      if (!enable || wrapEv) begin
        count <= CNT_W'(1);
      end else if (strobe.tick) begin
        count <= count + CNT_W'(1);
      end
    end
  end

  // Phase, dead time and latched polarity
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_PRI;
      deadCnt <= '0;
      latPol  <= 1'b1;
    end else if (idleOut) begin
      phase   <= PH_PRI;
      deadCnt <= '0;
      latPol  <= polarity;
    end else if (wrapEv) begin
      phase   <= PH_PRI;
      deadCnt <= deadband;
      latPol  <= polarity;
    end else if (matchEv) begin
      phase   <= PH_COMP;
      deadCnt <= deadband;
      latPol  <= polarity;
    end else if (deadCnt != '0) begin
      deadCnt <= deadCnt - DB_W'(1);
    end
  end

  // Capture register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      captureVal  <= '0;
      captureFlag <= 1'b0;
    end else begin
      captureFlag <= strobe.capEdge;
      if (strobe.capEdge) begin
        captureVal <= count;
      end
    end
  end

  AST_WRAP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    reloadPulse |-> count == CNT_W'(1));  // R3

  AST_CAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    captureFlag |=> !captureFlag);  // R10

  AST_CAP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || !capMode) |=> !captureFlag);  // R9

endmodule

// File: rtl/pwm_deadband_timer.sv
module pwm_deadband_timer
  import pwmdb_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 3,
  parameter int DB_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             capMode,
  input  logic             polarity,
  input  logic [PRE_W-1:0] prescale,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic [CNT_W-1:0] pwmVal,
  input  logic [DB_W-1:0]  deadband,
  input  logic             timerIn,
  output logic             outPri,
  output logic             outComp,
  output logic             reloadPulse,
  output logic [CNT_W-1:0] captureVal,
  output logic             captureFlag
);

  ctrlStrobe_t strobe;

  pwmdb_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .capMode  (capMode),
    .polarity (polarity),
    .prescale (prescale),
    .timerIn  (timerIn),
    .strobe   (strobe)
  );

  pwmdb_datapath #(.CNT_W(CNT_W), .DB_W(DB_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .capMode     (capMode),
    .polarity    (polarity),
    .reloadVal   (reloadVal),
    .pwmVal      (pwmVal),
    .deadband    (deadband),
    .strobe      (strobe),
    .outPri      (outPri),
    .outComp     (outComp),
    .reloadPulse (reloadPulse),
    .captureVal  (captureVal),
    .captureFlag (captureFlag)
  );

endmodule

// File: tb/pwm_deadband_timer_bench.sv
`timescale 1ns/1ps
module pwm_deadband_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        capMode = 1'b0;
  logic        polarity = 1'b1;
  logic [2:0]  prescale = '0;
  logic [15:0] reloadVal = 16'd10;
  logic [15:0] pwmVal = 16'd4;
  logic [2:0]  deadband = '0;
  logic        timerIn = 1'b0;
  logic        outPri;
  logic        outComp;
  logic        reloadPulse;
  logic [15:0] captureVal;
  logic        captureFlag;

  int errors = 0;
  int checks = 0;

  // polarity, prescale, reload, compare, dead time, period, primary-on, complement-on
  localparam int NVEC = 5;
  localparam int VEC [NVEC][8] = '{
    '{1, 0, 10, 4, 0, 10, 4, 6},
    '{1, 0, 10, 4, 2, 10, 2, 4},
    '{0, 1,  8, 3, 3, 16, 3, 7},
    '{1, 2,  5, 2, 7, 20, 1, 5},
    '{0, 0,  6, 5, 1,  6, 4, 0}
  };

  always #2 clk = ~clk;

  pwm_deadband_timer u_pwm_deadband_timer (
    .clk (clk), .rst_n (rst_n), .enable (enable), .capMode (capMode),
    .polarity (polarity), .prescale (prescale), .reloadVal (reloadVal),
    .pwmVal (pwmVal), .deadband (deadband), .timerIn (timerIn),
    .outPri (outPri), .outComp (outComp), .reloadPulse (reloadPulse),
    .captureVal (captureVal), .captureFlag (captureFlag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitPulse(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!reloadPulse && k < 5000);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 reset and disabled levels
    chk("R4 reset outPri", int'(outPri), 1);
    chk("R4 reset outComp", int'(outComp), 0);
    chk("R3 reset reloadPulse", int'(reloadPulse), 0);
    chk("R10 reset captureFlag", int'(captureFlag), 0);
    chk("R10 reset captureVal", int'(captureVal), 0);
    polarity = 1'b0;
    @(negedge clk);
    chk("R4 disabled pol0 outPri", int'(outPri), 0);
    chk("R4 disabled pol0 outComp", int'(outComp), 1);

    // Vector loop: R1 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      int period, priOn, compOn, bothOn, bothOff;
      enable    = 1'b0;
      polarity  = VEC[v][0][0];
      prescale  = 3'(VEC[v][1]);
      reloadVal = 16'(VEC[v][2]);
      pwmVal    = 16'(VEC[v][3]);
      deadband  = 3'(VEC[v][4]);
      repeat (2) @(negedge clk);
      enable = 1'b1;
      waitPulse(k);
      period = 0; priOn = 0; compOn = 0; bothOn = 0; bothOff = 0;
      do begin
        if (outPri == polarity) priOn++;
        if (outComp == polarity) compOn++;
        if (outPri == polarity && outComp == polarity) bothOn++;
        if (outPri != polarity && outComp != polarity) bothOff++;
        period++;
        @(negedge clk);
      end while (!reloadPulse && period < 5000);
      chk($sformatf("R1 vec%0d period", v), period, VEC[v][5]);
      chk($sformatf("R5 vec%0d primary on", v), priOn, VEC[v][6]);
      chk($sformatf("R5 vec%0d complement on", v), compOn, VEC[v][7]);
      chk($sformatf("R7 vec%0d both active", v), bothOn, 0);
      chk($sformatf("R6 vec%0d both inactive", v), bothOff, 2 * VEC[v][4]);
    end

    // R2 prescaler cleared by disable
    enable = 1'b0; polarity = 1'b1; prescale = 3'd2;
    reloadVal = 16'd2; pwmVal = 16'd1; deadband = '0;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    repeat (5) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    waitPulse(k);
    chk("R2 first reload after re-enable", k, 8);
    @(negedge clk);
    chk("R3 reload pulse width", int'(reloadPulse), 0);

    // R8 polarity change while running
    enable = 1'b0; polarity = 1'b1; prescale = 3'd0;
    reloadVal = 16'd10; pwmVal = 16'd4; deadband = '0;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    waitPulse(k);
    polarity = 1'b0;
    @(negedge clk);
    chk("R8 primary held after change", int'(outPri), 1);
    chk("R8 complement held after change", int'(outComp), 0);
    repeat (5) @(negedge clk);
    chk("R8 complement active low after match", int'(outComp), 0);
    chk("R8 primary inactive high after match", int'(outPri), 1);

    // Capture mode: R9 R10 R11
    enable = 1'b0; capMode = 1'b1; polarity = 1'b0; prescale = 3'd7;
    reloadVal = 16'd1000; timerIn = 1'b0;
    repeat (4) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    chk("R11 capture mode outPri", int'(outPri), 0);
    chk("R11 capture mode outComp", int'(outComp), 1);
    repeat (20) @(negedge clk);
    timerIn = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 flag not before third cycle", int'(captureFlag), 0);
    @(negedge clk);
    chk("R10 flag on rising edge", int'(captureFlag), 1);
    chk("R10 captured count", int'(captureVal), 1);
    @(negedge clk);
    chk("R10 flag one cycle", int'(captureFlag), 0);
    timerIn = 1'b0;
    k = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (captureFlag) k++;
    end
    chk("R9 falling edge ignored with pol0", k, 0);
    polarity = 1'b1;
    repeat (260) @(negedge clk);
    timerIn = 1'b1;
    k = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (captureFlag) k++;
    end
    chk("R9 rising edge ignored with pol1", k, 0);
    chk("R9 value kept after ignored edge", int'(captureVal), 1);
    timerIn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 flag on falling edge with pol1", int'(captureFlag), 1);
    chk("R10 captured count after two ticks", int'(captureVal), 3);
    chk("R11 capture mode outPri pol1", int'(outPri), 1);

    finishRun();
  end

endmodule